// File: doc/BRIEF.md
# Serial DAC Word Receiver with Chaining

This block is the digital front end of a 12-bit voltage-output converter. It takes a slow serial bus made of a frame select, a bit clock and a data line, together with a load strobe, a clear line, a chain enable and a format select. It samples all of these with a fast system clock. Each line passes through a synchronizer, and clock and strobe edges are found in the system-clock domain. Each frame carries a 16-bit word, most significant bit first. The first four bits are padding, and the last twelve bits are the converter code.

The shifted word moves into a holding latch in one of two ways. The first is a falling edge of the load strobe. The second is auto-update: while the strobe is held low, the latch loads by itself after the sixteenth bit-clock fall of a frame. The latch output goes to the converter core on an offset-binary scale. When two's-complement format is selected, the top bit is inverted on the way. A clear line empties the latch, which gives the bottom of scale in offset-binary mode and mid-scale (zero volts) in two's-complement mode.

A serial output presents the top bit of the shift register, so several receivers can be chained on one frame select. It is held low when chaining is disabled.

Top module: `sdac_rx_top`

## Requirements
- R1: After reset, `core_code` is 0x000 and `ser_dout` is 0.
- R2: While `frame_n` is low, each falling edge of `ser_clk` shifts `ser_din` into a 16-bit register, MSB first. A falling edge of `load_n` copies the last 12 bits shifted into the latch, and the 4 leading bits have no effect.
- R3: With `load_n` held high, a completed word does not change `core_code` until `load_n` falls.
- R4: With `load_n` held low, the latch loads by itself once the 16th falling `ser_clk` edge of a frame has been taken, without `frame_n` rising.
- R5: A frame ended by `frame_n` rising before its 16th edge triggers no auto-update. The bit count restarts from zero in the next frame.
- R6: `ser_clk` edges while `frame_n` is high leave the shift register unchanged.
- R7: With `chain_en` = 1, `ser_dout` shows the shift register's top bit. Bits shifted in beyond 16 push out the earlier word MSB first, one bit per falling `ser_clk` edge.
- R8: With `chain_en` = 0, `ser_dout` is 0.
- R9: While `clear_n` is low the latch holds all zeros. `core_code` is 0x000 when `fmt_twos` = 0 and 0x800 when `fmt_twos` = 1.
- R10: `core_code` equals the latch contents with bit 11 inverted when `fmt_twos` = 1, and unchanged when `fmt_twos` = 0.
- R11: A load that coincides with a low `clear_n` is lost, and the latch stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `ser_clk` |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Frame select, active low |
| ser_clk | input | 1 | Serial bit clock, data taken on its falling edge |
| ser_din | input | 1 | Serial data in, MSB first |
| load_n | input | 1 | Latch load strobe (falling edge); held low selects auto-update |
| clear_n | input | 1 | Active-low clear of the latch |
| chain_en | input | 1 | Enables the chaining output |
| fmt_twos | input | 1 | 1 = two's-complement input, 0 = binary |
| ser_dout | output | 1 | Chaining output, top bit of the shift register |
| core_code | output | 12 | Offset-binary code to the converter core |

## Verification
The state hardest to reach from the ports is a chained frame longer than 16 bits. In it, the shift register has to carry one word out while the next word comes in, and the bit counter must stay saturated without firing a second auto-update. The stimulus keeps `frame_n` low across two whole words and samples `ser_dout` after every falling edge of the second word against the first word's bits. A second hard case is a clear that lands in the same cycle as a load. The bench reaches it by lowering `clear_n` and `load_n` in the same system-clock cycle, so both reach the synchronizer outputs together.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
   // bit positions inside the synchronized pin vector
   localparam int PIN_FRAME = 0;
   localparam int PIN_SCLK  = 1;
   localparam int PIN_DIN   = 2;
   localparam int PIN_LOAD  = 3;
   localparam int PIN_CLEAR = 4;
   localparam int PIN_CHAIN = 5;
   localparam int PIN_FMT   = 6;
   localparam int PIN_COUNT = 7;
   // idle level of each pin, used as synchronizer reset value
   localparam logic [PIN_COUNT-1:0] PIN_IDLE = 7'b001_1001;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("sdac_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[gi] <= RST_VAL;
               else        stg[gi] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[gi] <= RST_VAL;
               else        stg[gi] <= stg[gi-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
   parameter int WORD_W = 16,
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_act,
   input  logic              bit_fall,
   input  logic              bit_in,
   output logic [CODE_W-1:0] code_bits,
   output logic              top_bit,
   output logic              word_done
);
   localparam int CNT_W = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

   generate
      if (CODE_W > WORD_W || CODE_W < 1) begin : g_bad
         $error("sdac_shifter: CODE_W must lie in 1..WORD_W");
      end
   endgenerate

   logic [WORD_W-1:0] sreg;
   logic [CNT_W-1:0]  cnt;
   logic              take;

   assign take = frame_act && bit_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg      <= '0;
         cnt       <= '0;
         word_done <= 1'b0;
      end else begin
         word_done <= take && (cnt == LAST);
         if (!frame_act) begin
            cnt <= '0;
         end else if (take) begin
            sreg <= {sreg[WORD_W-2:0], bit_in};
            if (cnt != FULL) cnt <= cnt + 1'b1;
         end
      end
   end

   assign code_bits = sreg[CODE_W-1:0];
   assign top_bit   = sreg[WORD_W-1];

   a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL);
   a_r5_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_act |=> cnt == '0);
   a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_act |=> $stable(sreg));
   a_r4_done_full: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |-> cnt == FULL);
endmodule

// File: rtl/sdac_latch.sv
module sdac_latch #(
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              load_evt,
   input  logic [CODE_W-1:0] din,
   input  logic              fmt_twos,
   output logic [CODE_W-1:0] core_code
);
   localparam logic [CODE_W-1:0] SIGN_FLIP = {1'b1, {(CODE_W-1){1'b0}}};

   logic [CODE_W-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        held <= '0;
      else if (clear)    held <= '0;
      else if (load_evt) held <= din;
   end

   assign core_code = fmt_twos ? (held ^ SIGN_FLIP) : held;

   a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> held == '0);
   a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clear && load_evt |=> held == '0);
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !clear && !load_evt |=> $stable(held));
endmodule

// File: rtl/sdac_rx_top.sv
module sdac_rx_top #(
   parameter int WORD_W = 16,
   parameter int CODE_W = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic              ser_clk,
   input  logic              ser_din,
   input  logic              load_n,
   input  logic              clear_n,
   input  logic              chain_en,
   input  logic              fmt_twos,
   output logic              ser_dout,
   output logic [CODE_W-1:0] core_code
);
   import sdac_pkg::*;

   logic [PIN_COUNT-1:0] pins_raw, pins_s;
   logic sclk_q, load_q;
   logic bit_fall, load_fall, load_evt;
   logic [CODE_W-1:0] code_bits;
   logic top_bit, word_done;

   always_comb begin
      pins_raw            = '0;
      pins_raw[PIN_FRAME] = frame_n;
      pins_raw[PIN_SCLK]  = ser_clk;
      pins_raw[PIN_DIN]   = ser_din;
      pins_raw[PIN_LOAD]  = load_n;
      pins_raw[PIN_CLEAR] = clear_n;
      pins_raw[PIN_CHAIN] = chain_en;
      pins_raw[PIN_FMT]   = fmt_twos;
   end

   sdac_sync #(.W(PIN_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= PIN_IDLE[PIN_SCLK];
         load_q <= PIN_IDLE[PIN_LOAD];
      end else begin
         sclk_q <= pins_s[PIN_SCLK];
         load_q <= pins_s[PIN_LOAD];
      end
   end

   assign bit_fall  = sclk_q && !pins_s[PIN_SCLK];
   assign load_fall = load_q && !pins_s[PIN_LOAD];
   // held-low strobe selects auto-update on a completed word
   assign load_evt  = load_fall || (!pins_s[PIN_LOAD] && word_done);

   sdac_shifter #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .frame_act(!pins_s[PIN_FRAME]),
      .bit_fall(bit_fall), .bit_in(pins_s[PIN_DIN]),
      .code_bits(code_bits), .top_bit(top_bit), .word_done(word_done));

   sdac_latch #(.CODE_W(CODE_W)) u_latch (
      .clk(clk), .rst_n(rst_n),
      .clear(!pins_s[PIN_CLEAR]), .load_evt(load_evt),
      .din(code_bits), .fmt_twos(pins_s[PIN_FMT]),
      .core_code(core_code));

   assign ser_dout = pins_s[PIN_CHAIN] && top_bit;

   a_r5_no_auto_unframed: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |-> $past(!pins_s[PIN_FRAME]));
endmodule

// File: tb/sdac_rx_top_test.sv
module sdac_rx_top_test;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic frame_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0, load_n = 1'b1;
   logic clear_n = 1'b1, chain_en = 1'b0, fmt_twos = 1'b0;
   logic ser_dout;
   logic [11:0] core_code;

   int n_tests = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdac_rx_top uut (.clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ser_clk(ser_clk),
      .ser_din(ser_din), .load_n(load_n), .clear_n(clear_n), .chain_en(chain_en),
      .fmt_twos(fmt_twos), .ser_dout(ser_dout), .core_code(core_code));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] expc(input logic [15:0] w, input logic f);
      return w[11:0] ^ {f, 11'b0};
   endfunction

   task automatic send_bit(input logic b);
      ser_din = b; ser_clk = 1'b1; tick(4);
      ser_clk = 1'b0; tick(4);
   endtask

   task automatic send_word(input logic [15:0] w, input int nbits);
      frame_n = 1'b0; tick(4);
      for (int i = 0; i < nbits; i++) send_bit(w[15-i]);
      tick(4);
   endtask

   task automatic strobe();
      load_n = 1'b0; tick(4);
      load_n = 1'b1; tick(6);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] prev, w, a, b;
      prev = 16'h0;
      tick(3); rst_n = 1'b1; tick(6);
      chk("R1 core", {4'h0, core_code}, 16'h000);
      chk("R1 dout", {15'h0, ser_dout}, 16'h0);

      // strobe-mode sweep, format alternating
      for (int k = 0; k < 64; k++) begin
         w = {k[3:0] ^ 4'hA, 12'((k * 67 + 13) & 12'hFFF)};
         fmt_twos = k[0];
         tick(6);
         send_word(w, 16);
         frame_n = 1'b1; tick(6);
         chk("R3 held until strobe", {4'h0, core_code}, {4'h0, expc(prev, k[0])});
         chk("R8 dout quiet", {15'h0, ser_dout}, 16'h0);
         strobe();
         chk("R2/R10 loaded code", {4'h0, core_code}, {4'h0, expc(w, k[0])});
         prev = w;
      end

      fmt_twos = 1'b0; tick(6);
      for (int j = 0; j < 12; j++) begin
         w = 16'hF000 | (16'h1 << j);
         send_word(w, 16); frame_n = 1'b1; tick(6); strobe();
         chk("R2 walking one", {4'h0, core_code}, {4'h0, expc(w, 1'b0)});
      end
      prev = w;

      // R6: edges outside a frame are ignored
      w = 16'h8ABC;
      send_word(w, 16); frame_n = 1'b1; tick(6); strobe();
      chain_en = 1'b1; tick(6);
      for (int i = 0; i < 5; i++) send_bit(1'b0);
      chk("R6 dout unchanged", {15'h0, ser_dout}, {15'h0, w[15]});
      strobe();
      chk("R6 register unchanged", {4'h0, core_code}, {4'h0, expc(w, 1'b0)});

      // R7: chained frame of 32 bits
      a = 16'hB5C3; b = 16'h9E21;
      send_word(a, 16);
      chk("R7 top bit", {15'h0, ser_dout}, {15'h0, a[15]});
      for (int i = 0; i < 16; i++) begin
         send_bit(b[15-i]);
         chk("R7 chained bit", {15'h0, ser_dout}, {15'h0, (i < 15) ? a[14-i] : b[15]});
      end
      frame_n = 1'b1; tick(6); strobe();
      chk("R7 second word code", {4'h0, core_code}, {4'h0, expc(b, 1'b0)});
      chain_en = 1'b0; tick(6);
      chk("R8 chain off", {15'h0, ser_dout}, 16'h0);

      // R9: clear per format
      clear_n = 1'b0; tick(6);
      chk("R9 clear offset", {4'h0, core_code}, 16'h000);
      fmt_twos = 1'b1; tick(6);
      chk("R9 clear twos", {4'h0, core_code}, 16'h800);
      clear_n = 1'b1; tick(6);
      chk("R9 stays clear", {4'h0, core_code}, 16'h800);
      fmt_twos = 1'b0; tick(6);

      // R11: clear and load together
      w = 16'h0FED;
      send_word(w, 16); frame_n = 1'b1; tick(6);
      clear_n = 1'b0; load_n = 1'b0; tick(6);
      chk("R11 clear beats load", {4'h0, core_code}, 16'h000);
      clear_n = 1'b1; load_n = 1'b1; tick(6);
      chk("R11 after release", {4'h0, core_code}, 16'h000);
      strobe();
      chk("R11 later load", {4'h0, core_code}, {4'h0, expc(w, 1'b0)});

      // R4/R5: auto-update
      load_n = 1'b0; tick(6);
      for (int k = 0; k < 6; k++) begin
         w = {4'h5, 12'((k * 611 + 7) & 12'hFFF)};
         fmt_twos = k[0]; tick(6);
         send_word(w, 16);
         chk("R4 auto load", {4'h0, core_code}, {4'h0, expc(w, k[0])});
         frame_n = 1'b1; tick(6);
         a = {4'h3, ~w[11:0]};
         send_word(a, 10); frame_n = 1'b1; tick(6);
         chk("R5 short word no load", {4'h0, core_code}, {4'h0, expc(w, k[0])});
         b = {4'hC, 12'(w[11:0] + 12'h123)};
         send_word(b, 16); frame_n = 1'b1; tick(6);
         chk("R5 count restart", {4'h0, core_code}, {4'h0, expc(b, k[0])});
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule